// File: doc/BRIEF.md
# Double-Precision Floating-Point Comparator with Invalid Flags

This block compares two 64-bit IEEE-754 binary64 operands, A and B. It returns a one-hot relation code that says whether A is less than, greater than or equal to B, or whether the pair is unordered. It also raises two invalid-operation indicators. One marks the presence of a signaling NaN. The other marks an ordered compare that met a NaN.

A caller presents both operands together with a compare-mode bit (ordered or unordered) and an invalid-exception-enable bit, then pulses `inValid` for one cycle. One cycle later `outDone` pulses and the registered results appear. The results stay unchanged until the next request. The block does not write any status register and does not deliver traps. The caller merges the flags into its own state.

Top module: `dfp_cmp_top`

## Requirements
- R1: `condCode` is one-hot for every completed compare, with bit 3 = less, bit 2 = greater, bit 1 = equal and bit 0 = unordered.
- R2: When either operand is a NaN (exponent all ones, fraction nonzero), only the unordered bit is set.
- R3: `flagSnan` is set when either operand is a signaling NaN (a NaN whose fraction bit 51 is 0), in both compare modes. It is clear otherwise.
- R4: `flagInvCmp` is set only for an ordered compare (`orderedMode`=1) with a NaN operand, and only when `invEnable` is 1 or either operand is a quiet NaN (fraction bit 51 is 1). An unordered compare never sets it.
- R5: Two zeros compare equal, whatever their signs.
- R6: When the signs differ and the operands are not both zero, a negative A gives less and a positive A gives greater.
- R7: Magnitudes order as zero < finite < infinity. Two infinities of the same sign compare equal.
- R8: For equal signs, finite values (denormals included) are ordered by the magnitude bits 62:0 as an unsigned integer. The less and greater results swap when both operands are negative. Equal bit patterns give equal.
- R9: `outDone` pulses for exactly one cycle, in the cycle after `inValid`. The results are valid in that same cycle.
- R10: After reset all outputs are 0. Between requests, `condCode`, `flagSnan` and `flagInvCmp` hold their last values, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | One-cycle request strobe |
| opA | input | 64 | Operand A, binary64 |
| opB | input | 64 | Operand B, binary64 |
| orderedMode | input | 1 | 1 = ordered compare, 0 = unordered compare |
| invEnable | input | 1 | Invalid-operation exception enable |
| outDone | output | 1 | Result-valid pulse |
| condCode | output | 4 | One-hot relation {less, greater, equal, unordered} |
| flagSnan | output | 1 | A signaling NaN was seen |
| flagInvCmp | output | 1 | Invalid ordered compare |

## Verification
The result registers load only on a request. A broken load enable therefore shows up in the cycle after the fault, either as a `condCode` that does not match the reference relation or as a change between requests. A wrong classification or sign-swap term shows in the first `outDone` cycle of any pair that uses it, so each corner class gets its own directed pair. A bad `outDone` sequencing shows as a pulse that is missing or lasts too long, one cycle after the strobe.

// File: rtl/dfp_cmp_pkg.sv
package dfp_cmp_pkg;
  localparam int CC_W  = 4;
  localparam int CC_LT = 3;
  localparam int CC_GT = 2;
  localparam int CC_EQ = 1;
  localparam int CC_UN = 0;

  typedef struct packed {
    logic loadResult;
  } cmpStrobeT;

  typedef struct packed {
    logic sign;
    logic isZero;
    logic isNan;
    logic isSnan;
    logic isQnan;
  } opClassT;
endpackage

// File: rtl/dfp_cmp_classify.sv
module dfp_cmp_classify
  import dfp_cmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] operand,
  output opClassT      cls,
  output logic [W-2:0] magnitude
);
  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;
  logic              expAllOnes;
  logic              fracNonZero;

  always_comb begin
    expField        = operand[W-2:FRAC_W];
    fracField       = operand[FRAC_W-1:0];
    expAllOnes      = &expField;
    fracNonZero     = |fracField;
    cls.sign        = operand[W-1];
    cls.isZero      = ~|operand[W-2:0];
    cls.isNan       = expAllOnes && fracNonZero;
    cls.isSnan      = cls.isNan && !fracField[FRAC_W-1];
    cls.isQnan      = cls.isNan && fracField[FRAC_W-1];
    magnitude       = operand[W-2:0];
  end
endmodule

// File: rtl/dfp_cmp_datapath.sv
module dfp_cmp_datapath
  import dfp_cmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  cmpStrobeT       strobes,
  input  logic [W-1:0]    opA,
  input  logic [W-1:0]    opB,
  input  logic            orderedMode,
  input  logic            invEnable,
  output logic [CC_W-1:0] condCode,
  output logic            flagSnan,
  output logic            flagInvCmp
);
  logic [W-1:0] opsIn [2];
  opClassT      cls   [2];
  logic [W-2:0] mag   [2];

  assign opsIn[0] = opA;
  assign opsIn[1] = opB;

  for (genvar g = 0; g < 2; g++) begin : gClass
    dfp_cmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_classify (
      .operand  (opsIn[g]),
      .cls      (cls[g]),
      .magnitude(mag[g])
    );
  end

  logic [CC_W-1:0] nextCc;
  logic            nextSnan;
  logic            nextInv;
  logic            anyNan;
  logic            magLess;

  always_comb begin
    anyNan   = cls[0].isNan || cls[1].isNan;
    magLess  = mag[0] < mag[1];
    nextCc   = '0;
    nextSnan = cls[0].isSnan || cls[1].isSnan;
    nextInv  = 1'b0;
    if (anyNan) begin
      nextCc[CC_UN] = 1'b1;
      nextInv = orderedMode && (invEnable || cls[0].isQnan || cls[1].isQnan);
    end else if (cls[0].isZero && cls[1].isZero) begin
      nextCc[CC_EQ] = 1'b1;
    end else if (cls[0].sign != cls[1].sign) begin
      if (cls[0].sign) nextCc[CC_LT] = 1'b1;
      else             nextCc[CC_GT] = 1'b1;
    end else if (mag[0] == mag[1]) begin
      nextCc[CC_EQ] = 1'b1;
    end else if (magLess ^ cls[0].sign) begin
      nextCc[CC_LT] = 1'b1;
    end else begin
      nextCc[CC_GT] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      condCode   <= '0;
      flagSnan   <= 1'b0;
      flagInvCmp <= 1'b0;
    end else if (strobes.loadResult) begin
      condCode   <= nextCc;
      flagSnan   <= nextSnan;
      flagInvCmp <= nextInv;
    end
  end
endmodule

// File: rtl/dfp_cmp_ctrl.sv
module dfp_cmp_ctrl
  import dfp_cmp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output cmpStrobeT strobes,
  output logic      outDone
);
  always_comb strobes.loadResult = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outDone <= 1'b0;
    else       outDone <= inValid;
  end
endmodule

// File: rtl/dfp_cmp_top.sv
module dfp_cmp_top
  import dfp_cmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [W-1:0]    opA,
  input  logic [W-1:0]    opB,
  input  logic            orderedMode,
  input  logic            invEnable,
  output logic            outDone,
  output logic [CC_W-1:0] condCode,
  output logic            flagSnan,
  output logic            flagInvCmp
);
  cmpStrobeT strobes;

  dfp_cmp_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .strobes(strobes),
    .outDone(outDone)
  );

  dfp_cmp_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .opA        (opA),
    .opB        (opB),
    .orderedMode(orderedMode),
    .invEnable  (invEnable),
    .condCode   (condCode),
    .flagSnan   (flagSnan),
    .flagInvCmp (flagInvCmp)
  );
endmodule

// File: rtl/dfp_cmp_checker.sv
module dfp_cmp_checker (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       orderedMode,
  input logic       outDone,
  input logic [3:0] condCode,
  input logic       flagSnan,
  input logic       flagInvCmp
);
  // R1: exactly one relation bit on every completed compare
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rstN)
    outDone |-> $countones(condCode) == 1);

  // R9: the done pulse follows the request by one cycle
  a_r9_done_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outDone);

  a_r9_done_only_after_req: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outDone);

  // R10: results hold between requests
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(condCode) && $stable(flagSnan) && $stable(flagInvCmp));

  // R4: an unordered-mode compare never raises the invalid-compare flag
  a_r4_unordered_mode: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !orderedMode) |=> !flagInvCmp);

  // R3/R4: invalid flags appear only with an unordered relation (R2)
  a_r2_flags_need_nan: assert property (@(posedge clk) disable iff (!rstN)
    (flagSnan || flagInvCmp) |-> condCode[0]);
endmodule

bind dfp_cmp_top dfp_cmp_checker i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .orderedMode(orderedMode),
  .outDone    (outDone),
  .condCode   (condCode),
  .flagSnan   (flagSnan),
  .flagInvCmp (flagInvCmp)
);

// File: tb/test_dfp_cmp_top.sv
module test_dfp_cmp_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        orderedMode = 1'b0;
  logic        invEnable = 1'b0;
  logic        outDone;
  logic [3:0]  condCode;
  logic        flagSnan;
  logic        flagInvCmp;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dfp_cmp_top i_dfp_cmp_top (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .orderedMode(orderedMode), .invEnable(invEnable), .outDone(outDone),
    .condCode(condCode), .flagSnan(flagSnan), .flagInvCmp(flagInvCmp)
  );

  localparam logic [63:0] PZERO = 64'h0000_0000_0000_0000;
  localparam logic [63:0] NZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0001;
  localparam logic [63:0] SNAN  = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] TWO   = 64'h4000_0000_0000_0000;
  localparam logic [63:0] NONE  = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] NTWO  = 64'hC000_0000_0000_0000;
  localparam logic [63:0] DEN1  = 64'h0000_0000_0000_0001;
  localparam logic [63:0] DEN2  = 64'h0000_0000_0000_0002;
  localparam logic [63:0] MAXF  = 64'h7FEF_FFFF_FFFF_FFFF;

  function automatic logic isNanF(logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
  endfunction

  function automatic logic [3:0] refCc(logic [63:0] a, logic [63:0] b);
    real ra, rb;
    if (isNanF(a) || isNanF(b)) return 4'b0001;
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    if (ra < rb) return 4'b1000;
    if (ra > rb) return 4'b0100;
    return 4'b0010;
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // issue one compare at a negedge and sample results one cycle later
  task automatic runCmp(string tag, logic [63:0] a, logic [63:0] b, logic ord, logic en);
    logic qa, qb, sa, sb, nan;
    @(negedge clk);
    opA = a; opB = b; orderedMode = ord; invEnable = en; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    nan = isNanF(a) || isNanF(b);
    qa = isNanF(a) && a[51];
    qb = isNanF(b) && b[51];
    sa = isNanF(a) && !a[51];
    sb = isNanF(b) && !b[51];
    check("R9", "done", {63'b0, outDone}, 64'd1);
    check(tag, "condCode", {60'b0, condCode}, {60'b0, refCc(a, b)});
    check(tag, "flagSnan", {63'b0, flagSnan}, {63'b0, sa || sb});
    check(tag, "flagInvCmp", {63'b0, flagInvCmp}, {63'b0, ord && nan && (en || qa || qb)});
  endtask

  task automatic testReset();
    check("R10", "reset done", {63'b0, outDone}, 64'd0);
    check("R10", "reset cc", {60'b0, condCode}, 64'd0);
    check("R10", "reset flags", {62'b0, flagSnan, flagInvCmp}, 64'd0);
  endtask

  task automatic testNan();
    runCmp("R2", QNAN, ONE, 1'b0, 1'b0);
    runCmp("R2", ONE, QNAN, 1'b0, 1'b1);
    runCmp("R3", SNAN, ONE, 1'b0, 1'b0);
    runCmp("R3", ONE, SNAN, 1'b1, 1'b0);
    runCmp("R4", SNAN, SNAN, 1'b1, 1'b0);
    runCmp("R4", SNAN, TWO, 1'b1, 1'b1);
    runCmp("R4", QNAN, SNAN, 1'b1, 1'b0);
    runCmp("R4", QNAN, QNAN, 1'b0, 1'b1);
    runCmp("R4", 64'hFFFF_FFFF_FFFF_FFFF, PINF, 1'b1, 1'b0);
  endtask

  task automatic testZeros();
    runCmp("R5", PZERO, NZERO, 1'b1, 1'b0);
    runCmp("R5", NZERO, PZERO, 1'b0, 1'b0);
    runCmp("R5", NZERO, NZERO, 1'b0, 1'b0);
  endtask

  task automatic testSigns();
    runCmp("R6", NONE, ONE, 1'b0, 1'b0);
    runCmp("R6", ONE, NTWO, 1'b0, 1'b0);
    runCmp("R6", NZERO, DEN1, 1'b0, 1'b0);
    runCmp("R6", PZERO, NINF, 1'b0, 1'b0);
  endtask

  task automatic testInf();
    runCmp("R7", PINF, PINF, 1'b1, 1'b0);
    runCmp("R7", NINF, NINF, 1'b1, 1'b0);
    runCmp("R7", MAXF, PINF, 1'b0, 1'b0);
    runCmp("R7", NINF, {1'b1, MAXF[62:0]}, 1'b0, 1'b0);
    runCmp("R7", PZERO, DEN1, 1'b0, 1'b0);
  endtask

  task automatic testFinite();
    runCmp("R8", ONE, TWO, 1'b0, 1'b0);
    runCmp("R8", NONE, NTWO, 1'b0, 1'b0);
    runCmp("R8", DEN2, DEN1, 1'b0, 1'b0);
    runCmp("R8", {1'b1, DEN2[62:0]}, {1'b1, DEN1[62:0]}, 1'b0, 1'b0);
    runCmp("R8", TWO, TWO, 1'b0, 1'b0);
    runCmp("R8", 64'h000F_FFFF_FFFF_FFFF, 64'h0010_0000_0000_0000, 1'b0, 1'b0);
  endtask

  task automatic testHold();
    logic [3:0] ccSeen;
    runCmp("R10", ONE, TWO, 1'b1, 1'b0);
    ccSeen = condCode;
    opA = SNAN; opB = QNAN; orderedMode = 1'b1; invEnable = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", "done single pulse", {63'b0, outDone}, 64'd0);
    check("R10", "hold cc", {60'b0, condCode}, {60'b0, ccSeen});
    check("R10", "hold flags", {62'b0, flagSnan, flagInvCmp}, 64'd0);
  endtask

  task automatic testRandom();
    for (int i = 0; i < 300; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = (i % 5 == 0) ? a : {$urandom, $urandom};
      if (i % 7 == 0) b[63] = a[63];
      if (i % 11 == 0) b[62:52] = a[62:52];
      runCmp("R1", a, b, i[0], i[1]);
      check("R1", "onehot", {63'b0, $countones(condCode) == 1}, 64'd1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    #1;
    testReset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    testNan();
    testZeros();
    testSigns();
    testInf();
    testFinite();
    testHold();
    testRandom();
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule